// File: doc/BRIEF.md
# SPI Master with Control/Status Register

This block is a single-channel serial peripheral master. Software drives it through two 16-bit registers on a simple synchronous register bus: a control/status word at address 0 and a data word at address 1. The control word picks the serial clock rate from a power-of-two table, turns the module on, starts a transfer, selects clock phase, clock polarity and transfer length, and reports completion through a sticky flag. That flag, gated by an interrupt-enable bit, drives a level interrupt output.

A transfer shifts the data word out on `mosi`, most significant bit first, and collects `miso` into the same word, right-aligned. The serial clock is made from the system clock. While a transfer runs, the start bit reads back as a busy flag, and data-register writes are dropped. Clearing the enable bit in the middle of a transfer aborts it. Writing 1 to the done flag raises it by hand so that the interrupt path can be exercised.

Top module: `spi_csr_master`

## Requirements
- R1: After reset the control word reads 0x0000, the data word reads 0x0000, `sclk` is 0 and `irq` is 0.
- R2: Control word layout: [15:13] rate code, [12:10] always read 0, [9] enable, [8] start/busy, [7] done, [6] interrupt enable, [5] phase, [4] polarity, [3:0] length code N. Bus address 0 selects the control word and address 1 the data word; `rdata` shows the selected word in the same cycle.
- R3: With rate code r, each `sclk` half period lasts H = 2<<r system clocks. The first `sclk` edge comes H clocks after the clock edge that accepts the start write, and the busy bit drops 2(N+1)H clocks after it.
- R4: A transfer moves N+1 bits. `mosi` carries data bits N down to 0. When the transfer ends, the data word holds the received bits in bits N..0, first received bit highest, and 0 above them. Exactly 2(N+1) `sclk` edges occur.
- R5: While no transfer runs, `sclk` sits at the polarity bit. It returns there at the end of a transfer.
- R6: Phase 0: `miso` is sampled and `mosi` is stable on the first edge of each bit, and `mosi` changes on the second edge. Phase 1: `mosi` changes on the first edge and is sampled on the second.
- R7: A start is accepted only when the enable bit is already 1 and the start write also carries enable = 1. Otherwise the start bit stays 0 and `sclk` does not toggle.
- R8: The start bit reads 1 for the whole transfer. It clears in the same clock in which the done flag sets.
- R9: While busy, writes to the data word are ignored. Writes to the rate, phase, polarity and length fields are also ignored.
- R10: The done flag is cleared by writing 0 and set by writing 1. `irq` equals done AND interrupt enable.
- R11: Writing enable = 0 during a transfer aborts it. The start bit clears, `sclk` returns to the polarity level, and both the done flag and the data word stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt request |

## Verification
Transfers are run across all four phase/polarity combinations, with lengths of 1, 4, 8 and 16 bits and rate codes 0, 1, 2 and 7. A bit-level slave model checks `mosi` on the sampling edge and feeds `miso` on the shifting edge, so a swapped phase, a wrong bit order or an off-by-one length shows up as a data mismatch. Edge counts, the time to the first edge and the total duration tell the divider table apart from a wrong half-period or a missing edge. Separate scenarios cover a start without enable, writes during busy, a mid-transfer abort, and setting and clearing the done flag by software. Together they distinguish a flag that completion drives from one that only software drives.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
    localparam int DATA_W = 16;
    localparam int RATE_W = 3;
    localparam int LEN_W  = 4;

    // bit positions of the control word (software decodes these)
    localparam int POS_RATE = 13;
    localparam int POS_EN   = 9;
    localparam int POS_XCH  = 8;
    localparam int POS_DONE = 7;
    localparam int POS_IE   = 6;
    localparam int POS_PHA  = 5;
    localparam int POS_POL  = 4;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              en;
        logic              done;
        logic              ie;
        logic              pha;
        logic              pol;
        logic [LEN_W-1:0]  len;
    } ctrl_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int RATE_W   = 3,
    parameter int MIN_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = $clog2(MIN_HALF) + (1 << RATE_W);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half;

    always_comb begin
        half  = CNT_W'(MIN_HALF) << rate;
        tick  = run && (cnt_q == half - 1'b1);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q < half);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              pha,
    input  logic              pol,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] txdata,
    input  logic              miso,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] rx_next,
    output logic              sclk,
    output logic              mosi
);
    localparam int EDGE_W = LEN_W + 2;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              mosi;
        logic [DATA_W-1:0] txsh;
        logic [DATA_W-1:0] rxsh;
        logic [EDGE_W-1:0] edge_n;
    } eng_t;

    eng_t cur_q, nxt_d;
    logic [EDGE_W-1:0] last_edge;
    logic [DATA_W-1:0] aligned;
    logic              leading;
    logic              sample_now;

    always_comb begin
        nxt_d      = cur_q;
        last_edge  = {(EDGE_W-1)'(len) + 1'b1, 1'b0} - 1'b1;
        aligned    = txdata << (DATA_W - 1 - int'(len));
        leading    = !cur_q.edge_n[0];
        sample_now = (leading != pha);
        finish     = 1'b0;

        if (abort) begin
            nxt_d.busy = 1'b0;
            nxt_d.sclk = pol;
        end else if (start) begin
            nxt_d.busy   = 1'b1;
            nxt_d.sclk   = pol;
            nxt_d.rxsh   = '0;
            nxt_d.edge_n = '0;
            if (!pha) begin
                nxt_d.mosi = aligned[DATA_W-1];
                nxt_d.txsh = aligned << 1;
            end else begin
                nxt_d.txsh = aligned;
            end
        end else if (cur_q.busy && tick) begin
            nxt_d.sclk   = !cur_q.sclk;
            nxt_d.edge_n = cur_q.edge_n + 1'b1;
            if (sample_now) begin
                nxt_d.rxsh = {cur_q.rxsh[DATA_W-2:0], miso};
            end else if (cur_q.edge_n != last_edge) begin
                nxt_d.mosi = cur_q.txsh[DATA_W-1];
                nxt_d.txsh = cur_q.txsh << 1;
            end
            if (cur_q.edge_n == last_edge) begin
                finish     = 1'b1;
                nxt_d.busy = 1'b0;
            end
        end else if (!cur_q.busy) begin
            nxt_d.sclk = pol;
        end
        rx_next = nxt_d.rxsh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy = cur_q.busy;
    assign sclk = cur_q.sclk;
    assign mosi = cur_q.mosi;

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.busy && $past(!cur_q.busy) && $stable(pol)) |-> cur_q.sclk == pol);
    // R4
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.busy |-> cur_q.edge_n <= last_edge);
endmodule

// File: rtl/spi_csr_master.sv
module spi_csr_master
    import spi_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    typedef struct packed {
        ctrl_t             cfg;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t             cur_q, nxt_d;
    logic              wr_ctrl, wr_data;
    logic              start, abort;
    logic              busy, finish, tick;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        nxt_d   = cur_q;
        wr_ctrl = bus_wr && !bus_addr;
        wr_data = bus_wr && bus_addr;
        start   = wr_ctrl && !busy && cur_q.cfg.en
                  && bus_wdata[POS_EN] && bus_wdata[POS_XCH];
        abort   = wr_ctrl && busy && !bus_wdata[POS_EN];

        if (wr_ctrl) begin
            nxt_d.cfg.en   = bus_wdata[POS_EN];
            nxt_d.cfg.done = bus_wdata[POS_DONE];
            nxt_d.cfg.ie   = bus_wdata[POS_IE];
            if (!busy) begin
                nxt_d.cfg.rate = bus_wdata[POS_RATE +: RATE_W];
                nxt_d.cfg.pha  = bus_wdata[POS_PHA];
                nxt_d.cfg.pol  = bus_wdata[POS_POL];
                nxt_d.cfg.len  = bus_wdata[LEN_W-1:0];
            end
        end
        if (wr_data && !busy) begin
            nxt_d.data = bus_wdata;
        end
        if (finish) begin
            nxt_d.cfg.done = 1'b1;
            nxt_d.data     = rx_next;
        end

        ctrl_word = '0;
        ctrl_word[POS_RATE +: RATE_W] = cur_q.cfg.rate;
        ctrl_word[POS_EN]   = cur_q.cfg.en;
        ctrl_word[POS_XCH]  = busy;
        ctrl_word[POS_DONE] = cur_q.cfg.done;
        ctrl_word[POS_IE]   = cur_q.cfg.ie;
        ctrl_word[POS_PHA]  = cur_q.cfg.pha;
        ctrl_word[POS_POL]  = cur_q.cfg.pol;
        ctrl_word[LEN_W-1:0] = cur_q.cfg.len;
        bus_rdata = bus_addr ? cur_q.data : ctrl_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq = cur_q.cfg.done && cur_q.cfg.ie;

    spi_rate_gen #(.RATE_W(RATE_W), .MIN_HALF(2)) i_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .rate (cur_q.cfg.rate),
        .tick (tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (abort),
        .tick   (tick),
        .pha    (nxt_d.cfg.pha),
        .pol    (nxt_d.cfg.pol),
        .len    (nxt_d.cfg.len),
        .txdata (cur_q.data),
        .miso   (miso),
        .busy   (busy),
        .finish (finish),
        .rx_next(rx_next),
        .sclk   (sclk),
        .mosi   (mosi)
    );

    // R8
    xch_fall_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cur_q.cfg.en) |-> cur_q.cfg.done);
    // R7
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cur_q.cfg.en));
    // R9
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cur_q.cfg.len) && $stable(cur_q.cfg.rate)
                                   && $stable(cur_q.cfg.pha) && $stable(cur_q.cfg.pol)));
endmodule

// File: tb/test_spi_csr_master.sv
module test_spi_csr_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #5 clk = !clk;

    spi_csr_master i_spi_csr_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int rate, input bit en, input bit xch, input bit done,
                                       input bit ie, input bit pha, input bit pol, input int len);
        return {3'(rate), 3'b000, en, xch, done, ie, pha, pol, 4'(len)};
    endfunction

    task automatic wr(input bit a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 1'b0;
    endtask

    task automatic wait_idle(input int lim);
        logic [15:0] s;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            rd(0, s);
            if (!s[8]) break;
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(0, v); check("R1 ctrl reset", v, 16'h0000);
        rd(1, v); check("R1 data reset", v, 16'h0000);
        check("R1 sclk reset", sclk, 0);
        check("R1 irq reset", irq, 0);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(1, 16'hA5C3);
        rd(1, v); check("R2 data readback", v, 16'hA5C3);
        wr(0, 16'h1C00);
        rd(0, v); check("R2 reserved bits read 0", v, 16'h0000);
        wr(0, mk(5, 0, 0, 0, 0, 1, 0, 9));
        rd(0, v); check("R2 field layout", v, 16'hA029);
        wr(0, 16'h0000);
    endtask

    // one full transfer with a bit-level slave model
    task automatic t_xfer(input int rate, input bit pha, input bit pol, input int n,
                          input bit ie, input logic [15:0] tx, input logic [15:0] sl);
        int h, cyc, e, first, mosi_err, idx;
        logic prev;
        logic [15:0] v, mask;
        h = 2 << rate;
        mask = 16'((32'h1 << (n + 1)) - 1);
        wr(1, tx);
        wr(0, mk(rate, 1, 0, 0, ie, pha, pol, n));
        check("R5 idle sclk at polarity", sclk, pol);
        miso = sl[n];
        wr(0, mk(rate, 1, 1, 0, ie, pha, pol, n));
        rd(0, v); check("R8 busy bit set", v[8], 1);
        cyc = 0; e = 0; first = -1; mosi_err = 0; prev = sclk;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (sclk !== prev) begin
                prev = sclk;
                e++;
                if (first < 0) first = cyc;
                if (((e % 2) == 1) == (pha == 0)) begin
                    idx = (e - 1) / 2;
                    if (mosi !== tx[n - idx]) mosi_err++;
                end else begin
                    idx = pha ? (e - 1) / 2 : e / 2;
                    if (idx <= n) miso = sl[n - idx];
                end
            end
            rd(0, v);
            if (!v[8]) break;
        end
        check("R3 first edge delay", first, h);
        check("R3 transfer duration", cyc, 2 * (n + 1) * h);
        check("R4 edge count", e, 2 * (n + 1));
        check("R6 mosi order and phase", mosi_err, 0);
        check("R5 sclk back at polarity", sclk, pol);
        check("R8 done set as busy clears", v[7], 1);
        check("R10 irq follows done and enable", irq, ie);
        rd(1, v); check("R4 received right-aligned", v, sl & mask);
        wr(0, mk(rate, 0, 0, 0, 0, pha, pol, n));
    endtask

    task automatic t_no_enable;
        logic [15:0] v;
        logic s0;
        wr(0, 16'h0000);
        s0 = sclk;
        wr(0, mk(0, 1, 1, 0, 0, 0, 0, 7));
        rd(0, v); check("R7 start without prior enable ignored", v[8], 0);
        repeat (20) @(negedge clk);
        check("R7 no sclk activity", sclk, s0);
        wr(0, mk(0, 0, 1, 0, 0, 0, 0, 7));
        rd(0, v); check("R7 start with enable cleared ignored", v[8], 0);
    endtask

    task automatic t_busy_writes;
        logic [15:0] v;
        miso = 1'b1;
        wr(1, 16'h1234);
        wr(0, mk(1, 1, 0, 0, 0, 0, 0, 7));
        wr(0, mk(1, 1, 1, 0, 0, 0, 0, 7));
        repeat (5) @(negedge clk);
        wr(1, 16'hBEEF);
        rd(1, v); check("R9 data write ignored while busy", v, 16'h1234);
        wr(0, mk(5, 1, 1, 0, 0, 1, 1, 3));
        rd(0, v); check("R9 config held while busy", {v[15:13], v[5:0]}, {3'd1, 6'h07});
        wait_idle(1000);
        rd(1, v); check("R9 data after busy transfer", v, 16'h00FF);
        miso = 1'b0;
        wr(0, 16'h0000);
    endtask

    task automatic t_abort;
        logic [15:0] v;
        logic s;
        wr(1, 16'h5555);
        wr(0, mk(3, 1, 0, 0, 0, 0, 1, 15));
        wr(0, mk(3, 1, 1, 0, 0, 0, 1, 15));
        repeat (40) @(negedge clk);
        wr(0, mk(3, 0, 0, 0, 0, 0, 1, 15));
        rd(0, v); check("R11 abort clears busy", v[8], 0);
        check("R11 abort leaves done clear", v[7], 0);
        check("R11 sclk at idle after abort", sclk, 1);
        s = sclk;
        repeat (50) @(negedge clk);
        check("R11 no sclk after abort", sclk, s);
        rd(1, v); check("R11 data unchanged by abort", v, 16'h5555);
        wr(0, 16'h0000);
    endtask

    task automatic t_done_flag;
        logic [15:0] v;
        wr(0, mk(0, 0, 0, 1, 1, 0, 0, 0));
        rd(0, v); check("R10 done set by writing 1", v[7], 1);
        check("R10 irq with enable", irq, 1);
        wr(0, mk(0, 0, 0, 1, 0, 0, 0, 0));
        check("R10 irq masked", irq, 0);
        wr(0, mk(0, 0, 0, 0, 1, 0, 0, 0));
        rd(0, v); check("R10 done cleared by writing 0", v[7], 0);
        check("R10 irq low after clear", irq, 0);
        wr(0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_xfer(0, 0, 0, 7, 1, 16'h00A6, 16'h003C);
        t_xfer(1, 1, 0, 7, 0, 16'h0059, 16'h00C5);
        t_xfer(0, 0, 1, 15, 1, 16'hB3E1, 16'h6D2A);
        t_xfer(2, 1, 1, 3, 1, 16'h000B, 16'h0006);
        t_xfer(7, 0, 0, 0, 1, 16'h0001, 16'h0001);
        t_xfer(0, 1, 0, 0, 0, 16'h0000, 16'h0001);
        t_no_enable();
        t_busy_writes();
        t_abort();
        t_done_flag();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule